// File: doc/BRIEF.md
# Multi-Mode Vector Load Unit

The block builds a 256-bit vector result from a byte-addressed memory that it reaches through a narrow read port. Each port request asks for one aligned 32-bit word, and the data for that request returns a fixed number of cycles later. A single command selects the shape of the load:
- a full 32-byte load that must sit on a 32-byte boundary;
- a full 32-byte load at any byte address;
- a 32-bit scalar copied into every lane;
- a per-lane masked load with zeroing, using either 32-bit or 64-bit lanes;
- a split load that fills each 128-bit half from its own address.

Internally every command is reduced to a list of byte regions. For each region the unit reads just enough aligned words to cover its byte span, shifts the bytes into place, and merges them into the result. A lane that the mask disables never becomes a region, so it never reaches the memory port. A caller pulses `start` while `busy` is low. `done` then pulses once when `result` and `fault` are final, and both stay unchanged until the next accepted command.

Top module: `vload_unit`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `memReq` are 0 and `result` is all zeros.
- R2: Mode code 0 is the aligned full load. With `addrLo[4:0]==0` it loads the 32 bytes starting at `addrLo`, with the lowest-addressed byte in result bits 7:0 and each following byte 8 bits higher. `done` is seen 8*MEM_LAT+11 cycles after the accepting edge.
- R3: Mode code 0 with `addrLo[4:0]!=0` sets `fault`, leaves `result` zero and issues no memory request. `done` follows in the cycle right after the accepting edge.
- R4: Mode code 1 loads the 32 bytes starting at any `addrLo`, in the same byte order as R2, with `fault` 0. Addresses wrap modulo 2^ADDR_W.
- R5: Mode code 2 reads the 32-bit little-endian value at any `addrLo` and places it in all eight 32-bit lanes.
- R6: Mode code 3 is the masked load. With `laneWide`=0 there are eight 4-byte lanes, and lane j is enabled by `laneMask[32j+31]`. With `laneWide`=1 there are four 8-byte lanes, and lane j is enabled by `laneMask[64j+63]`. An enabled lane j holds the bytes starting at `addrLo` + j*lane size. A disabled lane reads as zero.
- R7: A disabled lane issues no memory request. For each command, the number of requests equals the sum, over the regions that are loaded, of ceil((address mod 4 + region length)/4).
- R8: Mode code 4 fills result bits 127:0 with the 16 bytes at `addrLo` and bits 255:128 with the 16 bytes at `addrHi`. Neither address needs any alignment.
- R9: `start` is accepted only while `busy` is 0, and a `start` raised while busy has no effect on the running command. `done` is a one-cycle pulse. `result` and `fault` hold their values until the next accepted `start`.
- R10: Mode codes 5 to 7 are reserved. They set `fault`, give a zero `result` and issue no memory request.
- R11: Every request address is word aligned (`memAddr[1:0]==0`). The word requested on edge k is taken from `memRdata` on edge k+MEM_LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, accepted when not busy |
| mode | input | 3 | Load mode code (0 aligned, 1 unaligned, 2 broadcast, 3 masked, 4 split) |
| laneWide | input | 1 | Masked lane size: 0 = 32-bit, 1 = 64-bit |
| addrLo | input | ADDR_W | Base address (low half address in split mode) |
| addrHi | input | ADDR_W | High half address in split mode |
| laneMask | input | 256 | Lane enable vector, top bit of each lane used |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment or reserved-mode fault of the last command |
| result | output | 256 | Assembled vector |
| memReq | output | 1 | Word read request |
| memAddr | output | ADDR_W | Word-aligned byte address of the request |
| memRdata | input | 32 | Read word, valid MEM_LAT cycles after its request |

## Verification
A faulting command completes one edge after it is accepted. A load pays one setup cycle for each region, MEM_LAT+1 cycles for each word it reads, one merge cycle for each region that is loaded, and one closing setup cycle. That gives 8*MEM_LAT+11 edges for an aligned full load. The bench counts edges from the accepting edge up to the falling edge where `done` is first seen, and compares that count exactly for the aligned and faulting cases. For every other command it waits for `done` and only then samples `result`, `fault` and the request count. The memory model returns each word on the edge MEM_LAT cycles after its request, so a capture on the wrong edge picks up a poison word and shows up in the data check.

// File: rtl/vload_pkg.sv
package vload_pkg;
  localparam int VEC_BYTES = 32;
  localparam int WIN_WORDS = 9;  // worst case: 32 bytes at offset 3

  typedef enum logic [2:0] {
    MD_ALIGNED   = 3'd0,
    MD_UNALIGNED = 3'd1,
    MD_BCAST     = 3'd2,
    MD_MASKED    = 3'd3,
    MD_SPLIT     = 3'd4
  } ldMode_e;

  // strobes and region description from control to datapath
  typedef struct packed {
    logic       clrRes;
    logic       setFault;
    logic       capWord;
    logic [3:0] wordSel;
    logic       merge;
    logic [1:0] regOff;
    logic [5:0] regLen;
    logic [4:0] regDst;
    logic       replicate;
  } dpCtl_t;
endpackage

// File: rtl/vload_datapath.sv
module vload_datapath
  import vload_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int VEC_W  = VEC_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] memRdata,
  output logic [VEC_W-1:0]  result,
  output logic              fault
);
  localparam int WIN_W = WIN_WORDS * WORD_W;
  localparam int LANES = VEC_W / 32;

  logic [WIN_WORDS-1:0][WORD_W-1:0] window;
  logic [WIN_W-1:0] shifted;

  assign shifted = window >> {ctl.regOff, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      window <= '0;
      result <= '0;
      fault  <= 1'b0;
    end else begin
      if (ctl.clrRes) begin
        result <= '0;
        fault  <= ctl.setFault;
      end
      if (ctl.capWord) window[ctl.wordSel] <= memRdata;
      if (ctl.merge) begin
        for (int b = 0; b < VEC_BYTES; b++) begin
          if (b >= int'(ctl.regDst) && b < int'(ctl.regDst) + int'(ctl.regLen))
            result[b*8 +: 8] <= shifted[(b - int'(ctl.regDst))*8 +: 8];
        end
      end
      if (ctl.replicate) begin
        for (int l = 1; l < LANES; l++) result[l*32 +: 32] <= result[31:0];
      end
    end
  end

  AST_BCAST_LANES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.replicate |=> (result[255:128] == result[127:0]) && (result[63:32] == result[31:0])
                      && (result[127:64] == result[63:0])); // R5
endmodule

// File: rtl/vload_ctrl.sv
module vload_ctrl
  import vload_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MEM_LAT = 2,
  parameter int VEC_W   = VEC_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic              laneWide,
  input  logic [ADDR_W-1:0] addrLo,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic [VEC_W-1:0]  laneMask,
  output logic              busy,
  output logic              done,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output dpCtl_t            ctl
);
  localparam int CNT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_REQ, S_WAIT, S_MERGE, S_FIN} state_e;

  state_e state, stateNx;
  ldMode_e cmdMode;
  logic cmdWide;
  logic [ADDR_W-1:0] cmdA, cmdB;
  logic [VEC_W-1:0] cmdMask;
  logic [3:0] regIdx, wordIdx;
  logic [CNT_W-1:0] waitCnt;

  logic [3:0] regCnt, wordCnt;
  logic [ADDR_W-1:0] rAddr;
  logic [5:0] rLen;
  logic [4:0] rDst;
  logic rEn;
  logic [7:0] mIdx;
  logic faultNow;
  int laneB;

  // region list decode for the stored command
  always_comb begin
    laneB  = cmdWide ? 8 : 4;
    regCnt = 4'd1;
    rAddr  = cmdA;
    rLen   = 6'd32;
    rDst   = 5'd0;
    rEn    = 1'b1;
    mIdx   = 8'(int'(regIdx) * laneB * 8 + laneB * 8 - 1);
    case (cmdMode)
      MD_ALIGNED, MD_UNALIGNED: ;
      MD_BCAST: rLen = 6'd4;
      MD_SPLIT: begin
        regCnt = 4'd2;
        rLen   = 6'd16;
        rAddr  = regIdx[0] ? cmdB : cmdA;
        rDst   = regIdx[0] ? 5'd16 : 5'd0;
      end
      MD_MASKED: begin
        regCnt = cmdWide ? 4'd4 : 4'd8;
        rLen   = 6'(laneB);
        rAddr  = cmdA + ADDR_W'(int'(regIdx) * laneB);
        rDst   = 5'(int'(regIdx) * laneB);
        rEn    = (regIdx < regCnt) ? cmdMask[mIdx] : 1'b0;
      end
      default: regCnt = 4'd0;
    endcase
    wordCnt = 4'((6'(rAddr[1:0]) + rLen + 6'd3) >> 2);
  end

  assign faultNow = (mode == 3'(MD_ALIGNED) && addrLo[4:0] != 5'd0) || (mode > 3'(MD_SPLIT));
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign memReq  = (state == S_REQ);
  assign memAddr = {rAddr[ADDR_W-1:2], 2'b00} + ADDR_W'({wordIdx, 2'b00});

  always_comb begin
    stateNx       = state;
    ctl           = '0;
    ctl.regOff    = rAddr[1:0];
    ctl.regLen    = rLen;
    ctl.regDst    = rDst;
    ctl.wordSel   = wordIdx;
    case (state)
      S_IDLE: if (start) begin
        ctl.clrRes   = 1'b1;
        ctl.setFault = faultNow;
        stateNx      = faultNow ? S_FIN : S_SETUP;
      end
      S_SETUP: begin
        if (regIdx >= regCnt) begin
          ctl.replicate = (cmdMode == MD_BCAST);
          stateNx       = S_FIN;
        end else if (rEn) stateNx = S_REQ;
      end
      S_REQ:  stateNx = S_WAIT;
      S_WAIT: if (waitCnt == CNT_W'(MEM_LAT - 1)) begin
        ctl.capWord = 1'b1;
        stateNx     = (wordIdx == wordCnt - 4'd1) ? S_MERGE : S_REQ;
      end
      S_MERGE: begin
        ctl.merge = 1'b1;
        stateNx   = S_SETUP;
      end
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cmdMode <= MD_ALIGNED;
      cmdWide <= 1'b0;
      cmdA    <= '0;
      cmdB    <= '0;
      cmdMask <= '0;
      regIdx  <= '0;
      wordIdx <= '0;
      waitCnt <= '0;
    end else begin
      state <= stateNx;
      case (state)
        S_IDLE: if (start) begin
          cmdMode <= ldMode_e'(mode);
          cmdWide <= laneWide;
          cmdA    <= addrLo;
          cmdB    <= addrHi;
          cmdMask <= laneMask;
          regIdx  <= '0;
        end
        S_SETUP: begin
          wordIdx <= '0;
          if (regIdx < regCnt && !rEn) regIdx <= regIdx + 4'd1;
        end
        S_REQ: waitCnt <= '0;
        S_WAIT: begin
          if (waitCnt == CNT_W'(MEM_LAT - 1)) wordIdx <= wordIdx + 4'd1;
          else waitCnt <= waitCnt + CNT_W'(1);
        end
        S_MERGE: regIdx <= regIdx + 4'd1;
        default: ;
      endcase
    end
  end

  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R9
endmodule

// File: rtl/vload_unit.sv
module vload_unit
  import vload_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MEM_LAT = 2,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = VEC_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic              laneWide,
  input  logic [ADDR_W-1:0] addrLo,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic [VEC_W-1:0]  laneMask,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [VEC_W-1:0]  result,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [WORD_W-1:0] memRdata
);
  dpCtl_t ctl;

  vload_ctrl #(.ADDR_W(ADDR_W), .MEM_LAT(MEM_LAT), .VEC_W(VEC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .laneWide(laneWide),
    .addrLo(addrLo), .addrHi(addrHi), .laneMask(laneMask),
    .busy(busy), .done(done), .memReq(memReq), .memAddr(memAddr), .ctl(ctl)
  );

  vload_datapath #(.WORD_W(WORD_W), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .result(result), .fault(fault)
  );

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (result == '0)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(result) && $stable(fault))); // R9
endmodule

// File: tb/vload_unit_tb.sv
module vload_unit_tb;
  localparam int ADDR_W  = 16;
  localparam int MEM_LAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] mode = '0;
  logic laneWide = 1'b0;
  logic [15:0] addrLo = '0, addrHi = '0;
  logic [255:0] laneMask = '0;
  logic busy, done, fault, memReq;
  logic [255:0] result;
  logic [15:0] memAddr;
  logic [31:0] memRdata;

  int total = 0, bad = 0, reqCount = 0, badAlign = 0;
  logic [31:0] pipe [MEM_LAT];

  always #4 clk = ~clk;

  vload_unit #(.ADDR_W(ADDR_W), .MEM_LAT(MEM_LAT)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .laneWide(laneWide),
    .addrLo(addrLo), .addrHi(addrHi), .laneMask(laneMask), .busy(busy),
    .done(done), .fault(fault), .result(result), .memReq(memReq),
    .memAddr(memAddr), .memRdata(memRdata)
  );

  function automatic logic [7:0] mb(logic [15:0] a);
    logic [15:0] t;
    t = (a * 16'd29) ^ (a >> 7);
    return t[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] memWord(logic [15:0] a);
    return {mb(a + 16'd3), mb(a + 16'd2), mb(a + 16'd1), mb(a)};
  endfunction

  function automatic int words(logic [15:0] a, int len);
    return (int'(a[1:0]) + len + 3) / 4;
  endfunction

  // memory model: fixed latency, poison word when no request
  always @(posedge clk) begin
    pipe[0] <= memReq ? memWord(memAddr) : 32'hDEAD_BEEF;
    for (int i = 1; i < MEM_LAT; i++) pipe[i] <= pipe[i-1];
    if (memReq) begin
      reqCount++;
      if (memAddr[1:0] != 2'b00) badAlign++;
    end
  end
  assign memRdata = pipe[MEM_LAT-1];

  task automatic expCalc(input logic [2:0] md, input logic wd, input logic [15:0] a, b,
                         input logic [255:0] m, output logic [255:0] r, output logic f,
                         output int n);
    int lb;
    r = '0; f = 1'b0; n = 0;
    case (md)
      3'd0: if (a[4:0] != 5'd0) f = 1'b1;
            else begin
              for (int i = 0; i < 32; i++) r[i*8 +: 8] = mb(a + 16'(i));
              n = 8;
            end
      3'd1: begin
        for (int i = 0; i < 32; i++) r[i*8 +: 8] = mb(a + 16'(i));
        n = words(a, 32);
      end
      3'd2: begin
        for (int i = 0; i < 32; i++) r[i*8 +: 8] = mb(a + 16'(i % 4));
        n = words(a, 4);
      end
      3'd3: begin
        lb = wd ? 8 : 4;
        for (int j = 0; j < 32 / lb; j++) begin
          if (m[j*lb*8 + lb*8 - 1]) begin
            for (int i = 0; i < lb; i++) r[(j*lb + i)*8 +: 8] = mb(a + 16'(j*lb + i));
            n += words(a + 16'(j*lb), lb);
          end
        end
      end
      3'd4: begin
        for (int i = 0; i < 16; i++) begin
          r[i*8 +: 8]       = mb(a + 16'(i));
          r[(i+16)*8 +: 8]  = mb(b + 16'(i));
        end
        n = words(a, 16) + words(b, 16);
      end
      default: f = 1'b1;
    endcase
  endtask

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string tagOf(logic [2:0] md, logic [15:0] a);
    case (md)
      3'd0: return (a[4:0] == 5'd0) ? "R2" : "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic runCmd(input logic [2:0] md, input logic wd, input logic [15:0] a, b,
                        input logic [255:0] m, input int inject, output int cyc);
    logic [255:0] er; logic ef; int en; string tg;
    expCalc(md, wd, a, b, m, er, ef, en);
    tg = tagOf(md, a);
    @(negedge clk);
    mode = md; laneWide = wd; addrLo = a; addrHi = b; laneMask = m;
    start = 1'b1; reqCount = 0;
    @(negedge clk);
    start = 1'b0; cyc = 0;
    while (!done && cyc < 2000) begin
      if (cyc == inject) begin  // R9: start while busy must be ignored
        start = 1'b1; mode = 3'd2; addrLo = 16'h0203; laneMask = '0;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({tg, " done"}, 256'(done), 256'(1));
    chk({tg, " result"}, result, er);
    chk({tg, " fault"}, 256'(fault), 256'(ef));
    chk("R7 request count", 256'(reqCount), 256'(en));
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [255:0] er, m;
    logic ef;
    int en;
    logic [2:0] md;
    logic [15:0] a;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 256'(busy), 256'(0));
    chk("R1 done", 256'(done), 256'(0));
    chk("R1 fault", 256'(fault), 256'(0));
    chk("R1 memReq", 256'(memReq), 256'(0));
    chk("R1 result", result, '0);
    rstN = 1'b1;

    runCmd(3'd0, 1'b0, 16'h0040, 16'h0, '0, -1, cyc);          // R2
    chk("R2 latency", 256'(cyc), 256'(8 * MEM_LAT + 11));
    runCmd(3'd0, 1'b0, 16'h0044, 16'h0, '0, -1, cyc);          // R3
    chk("R3 latency", 256'(cyc), 256'(0));
    runCmd(3'd1, 1'b0, 16'h0107, 16'h0, '0, -1, cyc);          // R4
    runCmd(3'd1, 1'b0, 16'hFFF3, 16'h0, '0, -1, cyc);          // R4 wrap
    runCmd(3'd2, 1'b0, 16'h0203, 16'h0, '0, -1, cyc);          // R5
    m = '0;
    for (int j = 0; j < 8; j += 2) m[j*32 + 31] = 1'b1;
    runCmd(3'd3, 1'b0, 16'h0402, 16'h0, m, -1, cyc);           // R6 R7
    m = '0; m[63] = 1'b1; m[255] = 1'b1; m[150] = 1'b1;
    runCmd(3'd3, 1'b1, 16'h0301, 16'h0, m, -1, cyc);           // R6 R7
    runCmd(3'd3, 1'b0, 16'h0500, 16'h0, {8{32'h7FFF_FFFF}}, -1, cyc); // R7 all off
    runCmd(3'd4, 1'b0, 16'h0011, 16'h0F0E, '0, -1, cyc);       // R8
    runCmd(3'd6, 1'b0, 16'h0020, 16'h0, '0, -1, cyc);          // R10

    // R9: start while busy is ignored, then result and fault hold
    runCmd(3'd0, 1'b0, 16'h0080, 16'h0, '0, 5, cyc);
    expCalc(3'd0, 1'b0, 16'h0080, 16'h0, '0, er, ef, en);
    for (int k = 0; k < 10; k++) begin
      addrLo = 16'(k * 37); mode = 3'(k);
      @(negedge clk);
    end
    chk("R9 held result", result, er);
    chk("R9 held fault", 256'(fault), 256'(ef));
    chk("R9 idle", 256'({busy, done}), 256'(0));

    for (int t = 0; t < 60; t++) begin
      md = 3'($urandom % 6);
      if (md == 3'd5) md = 3'(5 + $urandom % 3);
      a = 16'($urandom);
      if (md == 3'd0 && ($urandom % 2) == 0) a[4:0] = 5'd0;
      for (int j = 0; j < 8; j++) m[j*32 +: 32] = $urandom;
      runCmd(md, 1'($urandom), a, 16'($urandom), m, -1, cyc);
    end

    chk("R11 word-aligned requests", 256'(badAlign), 256'(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule